// File: doc/BRIEF.md
# Flash Device Reset and Standby Controller

This block sits inside a serial flash device model and brings the device back to a known standby state. It responds to two events: power being applied, and an active-low hardware reset pin held low for long enough. The pin is resynchronised to the device clock, and a low level that does not last long enough is ignored. Once a reset is recognised, the block at once drops its ready flag, releases the data pins to high impedance and asks the operation engine to abandon any job still running. In the same cycle it pulses strobes that clear the volatile configuration and status bits and zero the bank address register.

When the pin is released, or when power comes up, the block starts the initialization phase. In this phase it writes all-ones into the program buffer, one word per clock, while an interval counter runs. Ready is reported only when the fill and the interval have both finished. A new qualified reset at any point, including during initialization, abandons the phase and starts it again from the beginning.

Top module: `flash_rst_ctrl`

## Requirements
- R1: The reset pin passes through SYNC_STAGES flops. A reset is recognised only after the pin has been sampled low on MIN_PULSE consecutive rising edges; a shorter low pulse changes no output.
- R2: In the cycle a reset is recognised, `ready` goes low and `ioTristate` goes high, and both stay that way until initialization ends. `ioTristate` is always the inverse of `ready`.
- R3: `opAbort` is high while a recognised reset is being held and `opBusy` is high. It follows `opBusy` in the same cycle.
- R4: `cfgVolClr`, `statVolClr` and `bankAddrClr` pulse together for exactly one cycle on each recognition.
- R5: During initialization, `bufWrEn` is high for BUF_DEPTH consecutive cycles. Addresses run 0, 1, … BUF_DEPTH-1, and `bufWrData` is all ones.
- R6: Initialization lasts max(INIT_CYCLES, BUF_DEPTH)+1 cycles. Ready rises on the (that+1)-th rising edge after power-up is sampled. After the pin is sampled high at edge a, ready rises on edge a+SYNC_STAGES+1+that.
- R7: A qualified reset during initialization abandons the fill. After release, the fill restarts at address 0 and the full interval runs again.
- R8: `cmdOut` follows `cmdIn` only while `ready` is high; otherwise it is 0.
- R9: While `powerGood` is low, `ready` is 0, `ioTristate` is 1, and `bufWrEn` and `cmdOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| powerGood | input | 1 | Low while power is absent; its rising edge starts power-up |
| resetPinN | input | 1 | Asynchronous active-low hardware reset pin |
| opBusy | input | 1 | Operation engine reports a job in progress |
| cmdIn | input | 1 | Command-valid from the decoder |
| opAbort | output | 1 | Abort request to the operation engine |
| ioTristate | output | 1 | High forces all data pins to high impedance |
| ready | output | 1 | Device is in standby and accepts commands |
| cmdOut | output | 1 | Command-valid gated by ready |
| cfgVolClr | output | 1 | Clear volatile configuration bits |
| statVolClr | output | 1 | Clear volatile status bits |
| bankAddrClr | output | 1 | Zero the bank address register |
| bufWrEn | output | 1 | Program buffer write enable |
| bufWrAddr | output | $clog2(BUF_DEPTH) | Program buffer write address |
| bufWrData | output | DATA_W | Program buffer write data |

## Verification
The bench builds the block with SYNC_STAGES=2, MIN_PULSE=4, INIT_CYCLES=10 and BUF_DEPTH=16. With these values the buffer fill, not the interval counter, decides when ready rises, so the gating of the end of initialization on fill completion shows up as a one-cycle-exact difference in timing. A short pulse of MIN_PULSE-1 samples sits exactly one sample below the recognition threshold. The small depth leaves room to interrupt a fill halfway through and watch it restart at address 0.

// File: rtl/frc_pkg.sv
package frc_pkg;

  typedef enum logic [1:0] {
    ST_START,
    ST_HOLD,
    ST_INIT,
    ST_READY
  } rstState_e;

  typedef struct packed {
    logic seqRun;
    logic clrVol;
    logic devReady;
  } seqStrobe_t;

endpackage

// File: rtl/frc_ctrl.sv
module frc_ctrl
  import frc_pkg::*;
(
  input  logic       clk,
  input  logic       powerGood,
  input  logic       pinQual,
  input  logic       fillDone,
  input  logic       initDone,
  output seqStrobe_t strb
);

  rstState_e stateQ, stateD;

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) stateQ <= ST_START;
    else            stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    if (pinQual) begin
      stateD = ST_HOLD;
    end else begin
      case (stateQ)
        ST_START: stateD = ST_INIT;
        ST_HOLD:  stateD = ST_INIT;
        ST_INIT:  if (fillDone && initDone) stateD = ST_READY;
        default:  stateD = stateQ;
      endcase
    end
  end

  always_comb begin
    strb.seqRun   = (stateQ == ST_INIT) && !pinQual;
    strb.clrVol   = pinQual && (stateQ != ST_HOLD);
    strb.devReady = (stateQ == ST_READY) && !pinQual;
  end

  // R4: a clear pulse never lasts two cycles
  assert_clear_single_R4: assert property (@(posedge clk) disable iff (!powerGood)
    strb.clrVol |=> !strb.clrVol);

  // R6: standby is entered only once both fill and interval have finished
  assert_ready_gated_R6: assert property (@(posedge clk) disable iff (!powerGood)
    (stateQ == ST_READY && $past(stateQ) == ST_INIT) |-> $past(fillDone && initDone));

  // R7: leaving the hold state always leads back into initialization
  assert_hold_to_init_R7: assert property (@(posedge clk) disable iff (!powerGood)
    (stateQ == ST_HOLD) |=> (stateQ == ST_HOLD || stateQ == ST_INIT));

endmodule

// File: rtl/frc_datapath.sv
module frc_datapath
  import frc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 8,
  parameter int INIT_CYCLES = 64,
  parameter int BUF_DEPTH   = 32,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              powerGood,
  input  logic              resetPinN,
  input  logic              opBusy,
  input  logic              cmdIn,
  input  seqStrobe_t        strb,
  output logic              pinQual,
  output logic              fillDone,
  output logic              initDone,
  output logic              opAbort,
  output logic              ioTristate,
  output logic              ready,
  output logic              cmdOut,
  output logic              cfgVolClr,
  output logic              statVolClr,
  output logic              bankAddrClr,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [DATA_W-1:0] bufWrData
);

  localparam int PW_W   = $clog2(MIN_PULSE + 1);
  localparam int FILL_W = $clog2(BUF_DEPTH + 1);
  localparam int INIT_W = $clog2(INIT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncLow;
  logic [PW_W-1:0]        lowCnt;
  logic [FILL_W-1:0]      fillCnt;
  logic [INIT_W-1:0]      initCnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge powerGood) begin
        if (!powerGood) syncQ <= '1;
        else            syncQ <= resetPinN;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge powerGood) begin
        if (!powerGood) syncQ <= '1;
        else            syncQ <= {syncQ[SYNC_STAGES-2:0], resetPinN};
      end
    end
  endgenerate

  assign syncLow = ~syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)                   lowCnt <= '0;
    else if (!syncLow)                lowCnt <= '0;
    else if (lowCnt != PW_W'(MIN_PULSE)) lowCnt <= lowCnt + 1'b1;
  end

  assign pinQual = (lowCnt == PW_W'(MIN_PULSE));

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      fillCnt <= '0;
      initCnt <= '0;
    end else if (!strb.seqRun) begin
      fillCnt <= '0;
      initCnt <= '0;
    end else begin
      if (!fillDone) fillCnt <= fillCnt + 1'b1;
      if (!initDone) initCnt <= initCnt + 1'b1;
    end
  end

  assign fillDone = (fillCnt == FILL_W'(BUF_DEPTH));
  assign initDone = (initCnt == INIT_W'(INIT_CYCLES));

  assign bufWrEn     = strb.seqRun && !fillDone;
  assign bufWrAddr   = fillCnt[ADDR_W-1:0];
  assign bufWrData   = '1;
  assign cfgVolClr   = strb.clrVol;
  assign statVolClr  = strb.clrVol;
  assign bankAddrClr = strb.clrVol;
  assign opAbort     = pinQual && opBusy;
  assign ready       = strb.devReady;
  assign ioTristate  = !strb.devReady;
  assign cmdOut      = cmdIn && strb.devReady;

  // R1: qualification needs the synchronised pin to have been low
  assert_qual_needs_low_R1: assert property (@(posedge clk) disable iff (!powerGood)
    pinQual |-> $past(syncLow));

  // R5: back-to-back buffer writes step the address by one
  assert_fill_step_R5: assert property (@(posedge clk) disable iff (!powerGood)
    (bufWrEn && $past(bufWrEn)) |-> bufWrAddr == ADDR_W'($past(bufWrAddr) + 1'b1));

endmodule

// File: rtl/flash_rst_ctrl.sv
module flash_rst_ctrl
  import frc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 8,
  parameter int INIT_CYCLES = 64,
  parameter int BUF_DEPTH   = 32,
  parameter int DATA_W      = 8
) (
  input  logic                         clk,
  input  logic                         powerGood,
  input  logic                         resetPinN,
  input  logic                         opBusy,
  input  logic                         cmdIn,
  output logic                         opAbort,
  output logic                         ioTristate,
  output logic                         ready,
  output logic                         cmdOut,
  output logic                         cfgVolClr,
  output logic                         statVolClr,
  output logic                         bankAddrClr,
  output logic                         bufWrEn,
  output logic [$clog2(BUF_DEPTH)-1:0] bufWrAddr,
  output logic [DATA_W-1:0]            bufWrData
);

  localparam int ADDR_W = $clog2(BUF_DEPTH);

  seqStrobe_t strb;
  logic       pinQual;
  logic       fillDone;
  logic       initDone;

  frc_ctrl u_ctrl (
    .clk      (clk),
    .powerGood(powerGood),
    .pinQual  (pinQual),
    .fillDone (fillDone),
    .initDone (initDone),
    .strb     (strb)
  );

  frc_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_PULSE  (MIN_PULSE),
    .INIT_CYCLES(INIT_CYCLES),
    .BUF_DEPTH  (BUF_DEPTH),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W)
  ) u_dp (
    .clk        (clk),
    .powerGood  (powerGood),
    .resetPinN  (resetPinN),
    .opBusy     (opBusy),
    .cmdIn      (cmdIn),
    .strb       (strb),
    .pinQual    (pinQual),
    .fillDone   (fillDone),
    .initDone   (initDone),
    .opAbort    (opAbort),
    .ioTristate (ioTristate),
    .ready      (ready),
    .cmdOut     (cmdOut),
    .cfgVolClr  (cfgVolClr),
    .statVolClr (statVolClr),
    .bankAddrClr(bankAddrClr),
    .bufWrEn    (bufWrEn),
    .bufWrAddr  (bufWrAddr),
    .bufWrData  (bufWrData)
  );

endmodule

// File: tb/flash_rst_ctrl_bench.sv
`timescale 1ns/1ps
module flash_rst_ctrl_bench;

  localparam int S      = 2;
  localparam int M      = 4;
  localparam int N      = 10;
  localparam int DEPTH  = 16;
  localparam int DW     = 8;
  localparam int AW     = $clog2(DEPTH);
  localparam int L      = ((N > DEPTH) ? N : DEPTH) + 1;
  localparam int PU_LAT = L + 1;
  localparam int RL_LAT = S + 2 + L;

  logic clk = 1'b0;
  logic powerGood = 1'b0;
  logic resetPinN = 1'b1;
  logic opBusy = 1'b0;
  logic cmdIn = 1'b0;
  logic opAbort, ioTristate, ready, cmdOut;
  logic cfgVolClr, statVolClr, bankAddrClr, bufWrEn;
  logic [AW-1:0] bufWrAddr;
  logic [DW-1:0] bufWrData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  flash_rst_ctrl #(
    .SYNC_STAGES(S), .MIN_PULSE(M), .INIT_CYCLES(N), .BUF_DEPTH(DEPTH), .DATA_W(DW)
  ) u_flash_rst_ctrl (
    .clk(clk), .powerGood(powerGood), .resetPinN(resetPinN), .opBusy(opBusy),
    .cmdIn(cmdIn), .opAbort(opAbort), .ioTristate(ioTristate), .ready(ready),
    .cmdOut(cmdOut), .cfgVolClr(cfgVolClr), .statVolClr(statVolClr),
    .bankAddrClr(bankAddrClr), .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr),
    .bufWrData(bufWrData)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Counts negedges until ready is seen; tracks buffer writes and clear pulses.
  task automatic runUntilReady(output int cyc, output int writes, output int clrs,
                               output int badWr);
    cyc = 0; writes = 0; clrs = 0; badWr = 0;
    while (cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (bufWrEn) begin
        if (int'(bufWrAddr) != writes || bufWrData != {DW{1'b1}}) badWr++;
        writes++;
      end
      if (cfgVolClr || statVolClr || bankAddrClr) clrs++;
      if (ready) break;
    end
  endtask

  task automatic testPowerUp();
    int cyc, writes, clrs, badWr;
    cmdIn = 1'b1;
    @(negedge clk);
    check("R9 ready low without power", ready, 0);
    check("R9 tristate without power", ioTristate, 1);
    check("R9 no buffer write without power", bufWrEn, 0);
    check("R9 cmd blocked without power", cmdOut, 0);
    powerGood = 1'b1;
    runUntilReady(cyc, writes, clrs, badWr);
    check("R6 power-up latency", cyc, PU_LAT);
    check("R5 power-up fill count", writes, DEPTH);
    check("R5 power-up fill order and data", badWr, 0);
    check("R2 outputs driven when ready", ioTristate, 0);
    check("R8 cmd passes when ready", cmdOut, 1);
  endtask

  task automatic testShortPulse();
    int clrs = 0, aborts = 0, notReady = 0;
    opBusy = 1'b1;
    resetPinN = 1'b0;
    repeat (M - 1) begin
      @(negedge clk);
      if (!ready) notReady++;
    end
    resetPinN = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!ready) notReady++;
      if (cfgVolClr || statVolClr || bankAddrClr) clrs++;
      if (opAbort) aborts++;
    end
    check("R1 short pulse keeps ready", notReady, 0);
    check("R1 short pulse no clears", clrs, 0);
    check("R1 short pulse no abort", aborts, 0);
    opBusy = 1'b0;
  endtask

  task automatic testFullReset();
    int firstLow = -1, clrs = 0, clrAtRec = 0, allThree = 0, abortAtRec = 0, triAtRec = 0;
    int cyc, writes, clrs2, badWr;
    opBusy = 1'b1;
    cmdIn  = 1'b1;
    resetPinN = 1'b0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (cfgVolClr || statVolClr || bankAddrClr) clrs++;
      if (!ready && firstLow < 0) begin
        firstLow   = i;
        clrAtRec   = cfgVolClr;
        allThree   = cfgVolClr && statVolClr && bankAddrClr;
        abortAtRec = opAbort;
        triAtRec   = ioTristate;
      end
    end
    check("R1 recognition cycle", firstLow, S + M);
    check("R2 tristate at recognition", triAtRec, 1);
    check("R4 clears at recognition", clrAtRec, 1);
    check("R4 all three clears together", allThree, 1);
    check("R4 single clear pulse", clrs, 1);
    check("R3 abort at recognition", abortAtRec, 1);
    check("R3 abort while held", opAbort, 1);
    check("R8 cmd blocked while held", cmdOut, 0);
    opBusy = 1'b0;
    #1;
    check("R3 abort follows busy", opAbort, 0);
    @(negedge clk);
    resetPinN = 1'b1;
    runUntilReady(cyc, writes, clrs2, badWr);
    check("R6 release latency", cyc, RL_LAT);
    check("R5 fill count after reset", writes, DEPTH);
    check("R5 fill order after reset", badWr, 0);
    check("R4 no clears after release", clrs2, 0);
  endtask

  task automatic testRestart();
    int cyc, writes, clrs2, badWr;
    int clrs = 0, readySeen = 0, midWrites = 0;
    resetPinN = 1'b0;
    repeat (10) @(negedge clk);
    resetPinN = 1'b1;
    repeat (S + 2 + 5) begin
      @(negedge clk);
      if (bufWrEn) midWrites++;
    end
    check("R7 fill under way before restart", (midWrites > 0 && midWrites < DEPTH) ? 1 : 0, 1);
    resetPinN = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (cfgVolClr) clrs++;
      if (ready) readySeen++;
    end
    check("R7 restart clears once", clrs, 1);
    check("R7 not ready during restart", readySeen, 0);
    resetPinN = 1'b1;
    runUntilReady(cyc, writes, clrs2, badWr);
    check("R7 full interval after restart", cyc, RL_LAT);
    check("R7 fill restarts at zero", badWr, 0);
    check("R7 full fill after restart", writes, DEPTH);
  endtask

  initial begin
    testPowerUp();
    testShortPulse();
    testFullReset();
    testRestart();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule